// File: doc/BRIEF.md
# Macro Processor ALU and Bitfield Datapath

This block is the execute datapath of a small macro processor. It holds the general register file and computes one result per instruction from two register operands. An opcode selects among five groups of operations:

- register ALU operations
- add-immediate
- bitfield merge
- extract-and-shift with the source bit position taken from a register
- extract-and-shift with the destination bit position taken from a register

A single persistent carry flag links the wide arithmetic. Only the arithmetic ALU sub-operations update it, and only when the sequencer commits the instruction. Everything else leaves the flag unchanged.

Operand reads and the result are combinational. The write-back port and the carry flag are registered. The sequencer presents the decoded fields, reads `result_o` in the same cycle, and writes the value it chooses back through the write port.

Register index 0 is a constant zero. This lets a single operation act as a move, a clear or a load-immediate.

Top module: `macro_alu_unit`

## Requirements
- R1: Register index 0 always reads as zero, and a write to index 0 is discarded. Indices 1 to 7 return the last value written through the write port, with the write taking effect at the clock edge. Every register reads zero after reset.
- R2: With opcode 0 (register ALU) and sub-op 0 (add), the result is x+y modulo 2^32. The candidate carry `carry_next_o` is 1 exactly when that result is unsigned-less than x.
- R3: With opcode 0 and sub-op 1 (add with carry), the result is x+y+carry modulo 2^32. The candidate carry is 1 exactly when the result is unsigned-less than x. This means y=0xFFFFFFFF with carry 1 gives result x and candidate carry 0.
- R4: With opcode 0 and sub-op 2 (subtract) or 3 (subtract with borrow), the result is x-y or x-y-carry modulo 2^32. The candidate carry is 1 exactly when the result is unsigned-greater than x.
- R5: With opcode 0, the logic sub-ops give these results, and for each of them `carry_next_o` equals `carry_o`:

  | Sub-op | Operation | Result |
  |---|---|---|
  | 4 | XOR | x^y |
  | 5 | OR | x\|y |
  | 6 | AND | x&y |
  | 7 | AND-NOT | x&~y |
  | 8 | NAND | ~(x&y) |

- R6: The carry flag reads 0 after reset. At a clock edge it takes the value of `carry_next_o` only when `exec_i` is 1, opcode is 0 and the sub-op is 0 to 3. Otherwise it holds its value.
- R7: With opcode 1 (add-immediate), the result is x plus the 18-bit immediate sign-extended to 32 bits. Immediate bit 17 is the sign bit.
- R8: With opcode 2 (merge), the field is the `size` bits of y starting at bit `src`. The result is x with its bits from `dst` upward replaced by that field. Field bits that land above bit 31 are dropped, and all other bits of x are kept.
- R9: With opcode 3, the source bit position is the value of register x and the destination position is the `dst` field. The result is ((y >> x) & mask) << dst, truncated to 32 bits.
- R10: With opcode 4, the source bit position is the `src` field and the destination position is the value of register x. The result is ((y >> src) & mask) << x, truncated to 32 bits.
- R11: For opcodes 3 and 4, when the value of register x is greater than 31 the result is 0.
- R12: The `size`, `src` and `dst` fields are 5 bits wide. The mask is (1<<size)-1, so a size of 0 selects no bits: merge returns x unchanged and extract returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | Commit strobe; lets an arithmetic op update the carry flag |
| op_i | input | 3 | Opcode (0 ALU, 1 add-immediate, 2 merge, 3 extract with register source position, 4 extract with register destination position) |
| alu_op_i | input | 4 | ALU sub-op (0..8) |
| src_x_i | input | 3 | Register index of operand x |
| src_y_i | input | 3 | Register index of operand y |
| imm_i | input | 18 | Signed immediate |
| fld_src_i | input | 5 | Bitfield source position |
| fld_dst_i | input | 5 | Bitfield destination position |
| fld_size_i | input | 5 | Bitfield width |
| wr_en_i | input | 1 | Register write enable |
| wr_idx_i | input | 3 | Register write index |
| wr_data_i | input | 32 | Register write data |
| result_o | output | 32 | Combinational result |
| carry_o | output | 1 | Current carry flag |
| carry_next_o | output | 1 | Carry value the current op would commit |

## Verification
The bench targets the wrap edges of the carry rule:
- An add-with-carry of 0xFFFFFFFF with carry set returns x and clears the carry. A design that computed a true 33-bit carry would wrongly report 1.
- A subtract that borrows through zero must set the carry.
- A logic op, or an arithmetic op without `exec_i`, must leave the flag untouched. A design that updated the flag on every op would lose a pending carry between the words of a multi-word add.

The bench also drives register-supplied bit positions of 31, 32 and 40, and field sizes of 0 and 31. A design that used only the low five bits of the register value would return shifted data instead of zero for the out-of-range positions. A design whose mask was 1<<size wide, or that overflowed when forming it, would corrupt merges at these sizes.

Finally, the bench writes to register 0 and checks that it still reads zero. It also checks that merged fields pushed past bit 31 are truncated rather than wrapped.

// File: rtl/macro_alu_pkg.sv
// Package: opcode and ALU sub-op encodings shared by the macro datapath.
// Assumes a 3-bit opcode and a 4-bit sub-op field from the decoder.
package macro_alu_pkg;

    typedef enum logic [2:0] {
        OP_ALU        = 3'd0,
        OP_ADDI       = 3'd1,
        OP_MERGE      = 3'd2,
        OP_XTR_SRCREG = 3'd3,
        OP_XTR_DSTREG = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        ALU_ADD  = 4'd0,
        ALU_ADDC = 4'd1,
        ALU_SUB  = 4'd2,
        ALU_SUBB = 4'd3,
        ALU_XOR  = 4'd4,
        ALU_OR   = 4'd5,
        ALU_AND  = 4'd6,
        ALU_ANDN = 4'd7,
        ALU_NAND = 4'd8
    } alu_e;

    // True for the sub-ops that produce and commit a carry.
    function automatic logic is_arith(input logic [3:0] sub);
        return sub <= 4'd3;
    endfunction

endpackage

// File: rtl/mac_regfile.sv
// Register file: NREG entries of DW bits with two combinational read
// ports and one synchronous write port. Entry 0 is a constant zero.
// Assumes the write index is valid whenever the write enable is high.
module mac_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 8,
    parameter int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] rd_a_idx,
    input  logic [RW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_a_data,
    output logic [DW-1:0] rd_b_data,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data
);

    logic [NREG-1:0][DW-1:0] file_q;

    // Write port: clears on reset, ignores index zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            file_q <= '0;
        end else if (wr_en && (wr_idx != '0)) begin
            file_q[wr_idx] <= wr_data;
        end
    end

    // Read ports: index zero is forced to zero.
    always_comb begin
        rd_a_data = (rd_a_idx == '0) ? '0 : file_q[rd_a_idx];
        rd_b_data = (rd_b_idx == '0) ? '0 : file_q[rd_b_idx];
    end

endmodule

// File: rtl/mac_arith.sv
// Register ALU: arithmetic and logic sub-ops with the carry rule that
// compares the wrapped result against operand x. Purely combinational.
// Assumes carry_in is the committed flag.
module mac_arith
    import macro_alu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    sub_op,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          carry_in,
    output logic [DW-1:0] res,
    output logic          carry_out
);

    logic [DW-1:0] sum;
    logic [DW-1:0] diff;

    // Adder and subtractor with optional carry or borrow in.
    always_comb begin
        sum  = x + y + {{(DW-1){1'b0}}, (sub_op == ALU_ADDC) & carry_in};
        diff = x - y - {{(DW-1){1'b0}}, (sub_op == ALU_SUBB) & carry_in};
    end

    // Sub-op select; logic ops pass the carry through.
    always_comb begin
        res       = '0;
        carry_out = carry_in;
        unique case (sub_op)
            ALU_ADD, ALU_ADDC: begin
                res       = sum;
                carry_out = sum < x;
            end
            ALU_SUB, ALU_SUBB: begin
                res       = diff;
                carry_out = diff > x;
            end
            ALU_XOR:  res = x ^ y;
            ALU_OR:   res = x | y;
            ALU_AND:  res = x & y;
            ALU_ANDN: res = x & ~y;
            ALU_NAND: res = ~(x & y);
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/mac_bitfield.sv
// Bitfield unit: merge and the two extract-and-shift variants. A
// register-supplied position above DW-1 yields zero. Combinational.
// Assumes size, src and dst are PW-bit immediates.
module mac_bitfield
    import macro_alu_pkg::*;
#(
    parameter int DW = 32,
    parameter int PW = $clog2(DW)
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic [PW-1:0] src_f,
    input  logic [PW-1:0] dst_f,
    input  logic [PW-1:0] size_f,
    output logic [DW-1:0] res
);

    localparam logic [DW-1:0] POS_MAX = DW[DW-1:0] - 1'b1;

    logic [DW:0]   mask_wide;
    logic [DW-1:0] mask;
    logic          x_in_range;
    logic [PW-1:0] x_pos;

    // Field mask computed one bit wider so the shift cannot overflow.
    always_comb begin
        mask_wide  = ({{DW{1'b0}}, 1'b1} << size_f) - 1'b1;
        mask       = mask_wide[DW-1:0];
        x_in_range = (x <= POS_MAX);
        x_pos      = x[PW-1:0];
    end

    // Variant select for the three bitfield opcodes.
    always_comb begin
        res = '0;
        unique case (op)
            OP_MERGE:
                res = (x & ~(mask << dst_f)) | (((y >> src_f) & mask) << dst_f);
            OP_XTR_SRCREG:
                res = x_in_range ? (((y >> x_pos) & mask) << dst_f) : '0;
            OP_XTR_DSTREG:
                res = x_in_range ? (((y >> src_f) & mask) << x_pos) : '0;
            default:
                res = '0;
        endcase
    end

endmodule

// File: rtl/macro_alu_unit.sv
// Top of the macro execute datapath: register file, ALU, add-immediate,
// bitfield unit and the persistent carry flag. The result and the
// candidate carry are combinational.
// Assumes the sequencer asserts exec_i once per committed instruction.
module macro_alu_unit
    import macro_alu_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NREG  = 8,
    parameter int IMM_W = 18,
    parameter int PW    = $clog2(DW),
    parameter int RW    = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_i,
    input  logic [2:0]       op_i,
    input  logic [3:0]       alu_op_i,
    input  logic [RW-1:0]    src_x_i,
    input  logic [RW-1:0]    src_y_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [PW-1:0]    fld_src_i,
    input  logic [PW-1:0]    fld_dst_i,
    input  logic [PW-1:0]    fld_size_i,
    input  logic             wr_en_i,
    input  logic [RW-1:0]    wr_idx_i,
    input  logic [DW-1:0]    wr_data_i,
    output logic [DW-1:0]    result_o,
    output logic             carry_o,
    output logic             carry_next_o
);

    logic [DW-1:0] opnd_x;
    logic [DW-1:0] opnd_y;
    logic [DW-1:0] alu_res;
    logic          alu_carry;
    logic [DW-1:0] bf_res;
    logic [DW-1:0] imm_ext;
    logic          carry_q;
    logic          arith_op;

    mac_regfile #(.DW(DW), .NREG(NREG), .RW(RW)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (src_x_i),
        .rd_b_idx  (src_y_i),
        .rd_a_data (opnd_x),
        .rd_b_data (opnd_y),
        .wr_en     (wr_en_i),
        .wr_idx    (wr_idx_i),
        .wr_data   (wr_data_i)
    );

    mac_arith #(.DW(DW)) i_arith (
        .sub_op    (alu_op_i),
        .x         (opnd_x),
        .y         (opnd_y),
        .carry_in  (carry_q),
        .res       (alu_res),
        .carry_out (alu_carry)
    );

    mac_bitfield #(.DW(DW), .PW(PW)) i_bitf (
        .op     (op_i),
        .x      (opnd_x),
        .y      (opnd_y),
        .src_f  (fld_src_i),
        .dst_f  (fld_dst_i),
        .size_f (fld_size_i),
        .res    (bf_res)
    );

    // Immediate sign extension and the arithmetic-op decode.
    always_comb begin
        imm_ext  = {{(DW-IMM_W){imm_i[IMM_W-1]}}, imm_i};
        arith_op = (op_i == OP_ALU) && is_arith(alu_op_i);
    end

    // Result select across the opcode groups.
    always_comb begin
        unique case (op_i)
            OP_ALU:  result_o = alu_res;
            OP_ADDI: result_o = opnd_x + imm_ext;
            OP_MERGE, OP_XTR_SRCREG, OP_XTR_DSTREG: result_o = bf_res;
            default: result_o = '0;
        endcase
    end

    // Carry flag: committed only by executed arithmetic ops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (exec_i && arith_op) begin
            carry_q <= alu_carry;
        end
    end

    assign carry_o      = carry_q;
    assign carry_next_o = arith_op ? alu_carry : carry_q;

endmodule

// File: rtl/macro_alu_chk.sv
// Checker for macro_alu_unit: carry commit rules, the zero register,
// add-immediate and the out-of-range extract positions.
module macro_alu_chk #(
    parameter int DW    = 32,
    parameter int NREG  = 8,
    parameter int IMM_W = 18,
    parameter int RW    = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exec_i,
    input logic [2:0]       op_i,
    input logic [3:0]       alu_op_i,
    input logic [RW-1:0]    src_x_i,
    input logic [RW-1:0]    src_y_i,
    input logic [IMM_W-1:0] imm_i,
    input logic [DW-1:0]    x_val,
    input logic [DW-1:0]    result_o,
    input logic             carry_o,
    input logic             carry_next_o
);

    localparam logic [DW-1:0] POS_MAX = DW[DW-1:0] - 1'b1;

    logic arith_now;
    assign arith_now = (op_i == 3'd0) && (alu_op_i <= 4'd3);

    // R6
    carry_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && arith_now) |=> (carry_o == $past(carry_next_o)));

    // R6
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_i && arith_now) |=> $stable(carry_o));

    // R5
    logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 && alu_op_i >= 4'd4 && alu_op_i <= 4'd8) |-> (carry_next_o == carry_o));

    // R1
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 && alu_op_i == 4'd5 && src_x_i == '0 && src_y_i == '0) |-> (result_o == '0));

    // R7
    addi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 && src_x_i == '0) |-> (result_o == {{(DW-IMM_W){imm_i[IMM_W-1]}}, imm_i}));

    // R11
    xtr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 3'd3 || op_i == 3'd4) && x_val > POS_MAX) |-> (result_o == '0));

endmodule

bind macro_alu_unit macro_alu_chk #(.DW(DW), .NREG(NREG), .IMM_W(IMM_W), .RW(RW)) i_macro_alu_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exec_i       (exec_i),
    .op_i         (op_i),
    .alu_op_i     (alu_op_i),
    .src_x_i      (src_x_i),
    .src_y_i      (src_y_i),
    .imm_i        (imm_i),
    .x_val        (opnd_x),
    .result_o     (result_o),
    .carry_o      (carry_o),
    .carry_next_o (carry_next_o)
);

// File: tb/test_macro_alu_unit.sv
// Directed bench for macro_alu_unit; each task checks its own scenario.
module test_macro_alu_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [3:0]  alu_op_i = '0;
    logic [2:0]  src_x_i = '0;
    logic [2:0]  src_y_i = '0;
    logic [17:0] imm_i = '0;
    logic [4:0]  fld_src_i = '0;
    logic [4:0]  fld_dst_i = '0;
    logic [4:0]  fld_size_i = '0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_idx_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] result_o;
    logic        carry_o;
    logic        carry_next_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [31:0] regs_m [8];
    logic        carry_m = 1'b0;

    always #2 clk = ~clk;

    macro_alu_unit i_macro_alu_unit (
        .clk (clk), .rst_n (rst_n), .exec_i (exec_i), .op_i (op_i),
        .alu_op_i (alu_op_i), .src_x_i (src_x_i), .src_y_i (src_y_i),
        .imm_i (imm_i), .fld_src_i (fld_src_i), .fld_dst_i (fld_dst_i),
        .fld_size_i (fld_size_i), .wr_en_i (wr_en_i), .wr_idx_i (wr_idx_i),
        .wr_data_i (wr_data_i), .result_o (result_o), .carry_o (carry_o),
        .carry_next_o (carry_next_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] val);
        @(negedge clk);
        wr_en_i = 1'b1; wr_idx_i = idx[2:0]; wr_data_i = val;
        @(negedge clk);
        wr_en_i = 1'b0;
        if (idx != 0) regs_m[idx] = val;
    endtask

    task automatic drive(input int op, input int aop, input int x, input int y,
                         input logic [17:0] imm, input int s, input int d, input int z);
        @(negedge clk);
        op_i = op[2:0]; alu_op_i = aop[3:0]; src_x_i = x[2:0]; src_y_i = y[2:0];
        imm_i = imm; fld_src_i = s[4:0]; fld_dst_i = d[4:0]; fld_size_i = z[4:0];
        #1;
    endtask

    // Commit the currently driven op and wait past the edge.
    task automatic commit;
        exec_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        exec_i = 1'b0;
        #1;
    endtask

    // Reference model of the register ALU, written from R2 to R5.
    function automatic logic [32:0] ref_alu(input int aop, input logic [31:0] x,
                                            input logic [31:0] y, input logic c);
        logic [31:0] r;
        logic cn;
        cn = c;
        case (aop)
            0: begin r = x + y;      cn = r < x; end
            1: begin r = x + y + {31'd0, c}; cn = r < x; end
            2: begin r = x - y;      cn = r > x; end
            3: begin r = x - y - {31'd0, c}; cn = r > x; end
            4: r = x ^ y;
            5: r = x | y;
            6: r = x & y;
            7: r = x & ~y;
            default: r = ~(x & y);
        endcase
        return {cn, r};
    endfunction

    function automatic logic [31:0] ref_field(input logic [31:0] y, input int sb,
                                              input int db, input int sz);
        logic [63:0] m;
        logic [63:0] v;
        if (sb > 31 || db > 31) return 32'd0;
        m = (64'd1 << sz) - 64'd1;
        v = ((({32'd0, y}) >> sb) & m) << db;
        return v[31:0];
    endfunction

    task automatic t_reset;
        chk("R6 carry after reset", {31'd0, carry_o}, 32'd0);
        drive(0, 5, 3, 0, 18'd0, 0, 0, 0);
        chk("R1 reg3 after reset", result_o, 32'd0);
    endtask

    task automatic t_regs;
        wr(0, 32'hDEAD_BEEF);
        drive(0, 5, 0, 0, 18'd0, 0, 0, 0);
        chk("R1 write to r0 discarded", result_o, 32'd0);
        for (int i = 1; i < 8; i++) wr(i, 32'h1111_1111 * i);
        for (int i = 1; i < 8; i++) begin
            drive(0, 5, i, 0, 18'd0, 0, 0, 0);
            chk("R1 register readback", result_o, regs_m[i]);
        end
    endtask

    task automatic alu_case(input string tag, input int aop, input int x, input int y);
        logic [32:0] e;
        e = ref_alu(aop, regs_m[x], regs_m[y], carry_m);
        drive(0, aop, x, y, 18'd0, 0, 0, 0);
        chk({tag, " result"}, result_o, e[31:0]);
        chk({tag, " carry_next"}, {31'd0, carry_next_o}, {31'd0, e[32]});
    endtask

    task automatic t_arith;
        wr(1, 32'hFFFF_FFFF); wr(2, 32'd1); wr(3, 32'd5); wr(4, 32'd7);
        alu_case("R2 add wrap", 0, 1, 2);
        commit; carry_m = 1'b1;
        chk("R6 carry committed", {31'd0, carry_o}, 32'd1);
        alu_case("R2 add small", 0, 3, 4);
        alu_case("R3 addc", 1, 3, 4);
        alu_case("R3 addc y all ones", 1, 3, 1);
        commit; carry_m = 1'b0;
        chk("R3 addc quirk clears carry", {31'd0, carry_o}, 32'd0);
        alu_case("R4 sub borrow", 2, 3, 4);
        commit; carry_m = 1'b1;
        alu_case("R4 subb with borrow", 3, 4, 3);
        alu_case("R4 subb y all ones", 3, 3, 1);
        alu_case("R4 sub zero operand", 2, 0, 2);
    endtask

    task automatic t_logic;
        wr(5, 32'hF0F0_1234); wr(6, 32'h0FF0_FF00);
        for (int a = 4; a <= 8; a++) begin
            alu_case("R5 logic op", a, 5, 6);
            chk("R5 carry unchanged", {31'd0, carry_next_o}, {31'd0, carry_o});
        end
        commit;
        chk("R6 logic commit holds carry", {31'd0, carry_o}, {31'd0, carry_m});
        // Arithmetic op that would clear the carry, not committed.
        drive(0, 0, 3, 4, 18'd0, 0, 0, 0);
        @(posedge clk); @(negedge clk); #1;
        chk("R6 no exec holds carry", {31'd0, carry_o}, {31'd0, carry_m});
        drive(1, 0, 3, 0, 18'd0, 0, 0, 0);
        commit;
        chk("R6 addi commit holds carry", {31'd0, carry_o}, {31'd0, carry_m});
    endtask

    task automatic t_imm;
        wr(1, 32'd10);
        drive(1, 0, 1, 0, 18'h3FFFF, 0, 0, 0);
        chk("R7 addi minus one", result_o, 32'd9);
        drive(1, 0, 1, 0, 18'h1FFFF, 0, 0, 0);
        chk("R7 addi max positive", result_o, 32'd10 + 32'd131071);
        drive(1, 0, 1, 0, 18'h20000, 0, 0, 0);
        chk("R7 addi most negative", result_o, 32'd10 - 32'd131072);
    endtask

    task automatic merge_case(input string tag, input int s, input int d, input int z);
        logic [63:0] m;
        logic [31:0] e;
        m = ((64'd1 << z) - 64'd1) << d;
        e = (regs_m[1] & ~m[31:0]) | ref_field(regs_m[2], s, d, z);
        drive(2, 0, 1, 2, 18'd0, s, d, z);
        chk(tag, result_o, e);
    endtask

    task automatic t_merge;
        wr(1, 32'hFFFF_FFFF); wr(2, 32'h0000_00A5);
        merge_case("R8 merge byte", 0, 8, 8);
        merge_case("R12 merge size zero", 3, 4, 0);
        merge_case("R12 merge size 31", 0, 0, 31);
        wr(1, 32'h0000_0000); wr(2, 32'h0000_00AB);
        merge_case("R8 merge truncated at top", 0, 28, 8);
        merge_case("R8 merge with source offset", 4, 0, 4);
    endtask

    task automatic t_extract;
        wr(2, 32'h0000_00F0); wr(3, 32'd4); wr(4, 32'd32); wr(5, 32'd31);
        wr(6, 32'd28); wr(7, 32'd40); wr(1, 32'h8000_0000);
        drive(3, 0, 3, 2, 18'd0, 0, 8, 4);
        chk("R9 extract source from reg", result_o, ref_field(32'hF0, 4, 8, 4));
        drive(3, 0, 4, 2, 18'd0, 0, 8, 4);
        chk("R11 source position 32", result_o, 32'd0);
        drive(3, 0, 5, 1, 18'd0, 0, 0, 1);
        chk("R9 source position 31", result_o, 32'd1);
        drive(4, 0, 6, 2, 18'd0, 4, 0, 4);
        chk("R10 extract dest from reg", result_o, 32'hF000_0000);
        drive(4, 0, 7, 2, 18'd0, 4, 0, 4);
        chk("R11 dest position 40", result_o, 32'd0);
        drive(4, 0, 3, 2, 18'd0, 4, 0, 0);
        chk("R12 extract size zero", result_o, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) regs_m[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset;
        t_regs;
        t_arith;
        t_logic;
        t_imm;
        t_merge;
        t_extract;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule